// File: doc/BRIEF.md
# Flash Page Program Sequencer

This block writes an arbitrary byte range into a serial NOR flash, or erases a range of it, by issuing the flash command sequence itself. It is given a start pulse, a flash byte offset, a source memory address and a length. It splits the range into chunks. It then drives one command at a time on a request/response port. A serial shifter and the data memory sit behind that port.

In program mode a chunk never crosses a 256-byte page. Each attempt at a chunk sends a write enable, then a page program, then status reads until the flash reports idle. A chunk is accepted after two confirmed completions, within four attempts. A write disable always closes the chunk. In erase mode the block steps through the range 4 KB at a time. Each step uses a sector erase, wrapped in status reads, under the same completion rules. The operation ends with a one-cycle done pulse or a one-cycle error pulse.

Top module: `flash_prog_seq`

## Requirements
- R1: A start with length 0 gives an error pulse one cycle later. It issues no command, and busy stays low.
- R2: After an accepted start, busy is high from the next cycle until the cycle in which done or error pulses. A start pulse while busy is ignored, and so are changes on the start inputs.
- R3: The first program chunk at offset O holds min(L, 256 - O mod 256) bytes. Every later chunk holds 256 bytes or the remainder. The page program carries the chunk start as its address and the chunk size as its byte count. Its memory address advances by the same amount as the offset.
- R4: A program attempt issues write enable (opcode 0x06, no address, count 0). Next comes page program (0x02, address valid). Then come status reads (0x05, no address, count 1).
- R5: Status bit 0 is the busy flag. An attempt completes when a status read returns it clear. Attempts repeat until 2 completions are counted or 4 attempts are made, so a flash that becomes ready gets exactly 2 attempts.
- R6: An attempt whose status reads all show busy ends without a completion after PollLimit reads.
- R7: In program mode, write disable (0x04, no address, count 0) follows every chunk's attempt loop, even a failed one. A chunk with fewer than 2 completions then raises error, and no further command is issued.
- R8: In erase mode the range is covered in ceil(L/4096) steps. The address starts at O and grows by 4096 each step. Each attempt sends write enable, one status read, sector erase (0x20, address valid, count 0), one status read, and then the polling reads. The status read just after the erase counts toward its busy sequence. No write disable is sent.
- R9: Opcode, address, byte count and memory address are held stable with the request valid until the acknowledge cycle. The status byte is taken in that cycle.
- R10: After the last chunk succeeds, done pulses for exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| startPulse | input | 1 | Starts an operation when idle |
| eraseMode | input | 1 | 1 selects sector erase, 0 selects page program |
| startOffset | input | AddrW | Flash byte offset of the range |
| startMem | input | MemW | Source memory address for program data |
| startLen | input | LenW | Length of the range in bytes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle success pulse |
| error | output | 1 | One-cycle failure or reject pulse |
| cmdValid | output | 1 | Command request valid |
| cmdOpcode | output | 8 | Flash opcode |
| cmdAddrValid | output | 1 | Request carries a 3-byte address |
| cmdAddr | output | AddrW | Flash address, 0 when unused |
| cmdByteCount | output | LenW | Data bytes moved with the command |
| cmdMemAddr | output | MemW | Memory address of program data, 0 otherwise |
| cmdAck | input | 1 | Request accepted and response present |
| cmdStatus | input | 8 | Status byte returned with a status read |

## Verification
The bench captures every command that is acknowledged and compares it with a command list built from the requirements. A wrong chunk size, a lost offset or an off-by-one attempt or completion counter therefore shows up as a mismatch in the very command where the two lists part. A poll counter that stops too early or too late changes the number of status reads in the failing-flash cases, at the boundary read. A corrupted state shows up as a missing or extra write disable before the done or error pulse, or as a pulse in the wrong place.

// File: rtl/fps_pkg.sv
package fps_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_WRDI  = 8'h04;
  localparam logic [7:0] OP_PROG  = 8'h02;
  localparam logic [7:0] OP_STAT  = 8'h05;
  localparam logic [7:0] OP_ERASE = 8'h20;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WREN, ST_PRESR, ST_ERASE, ST_POSTSR,
    ST_PROG, ST_POLL, ST_SETTLE, ST_WRDI, ST_CHECK
  } seqState_e;

  typedef struct packed {
    logic load;        // capture start inputs, clear chunk counters
    logic advance;     // move to the next chunk
    logic attemptEnd;  // one attempt finished
    logic markDone;    // that attempt saw the flash idle
    logic clrPoll;     // restart status read count
    logic incPoll;     // one status read answered
  } dpCtl_t;
endpackage

// File: rtl/fps_datapath.sv
module fps_datapath
  import fps_pkg::*;
#(
  parameter int AddrW       = 24,
  parameter int MemW        = 32,
  parameter int LenW        = 24,
  parameter int PageBytes   = 256,
  parameter int SectorBytes = 4096,
  parameter int MaxAttempts = 4,
  parameter int NeedDone    = 2,
  parameter int PollLimit   = 50000
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpCtl_t           ctl,
  input  logic             startErase,
  input  logic [AddrW-1:0] startOffset,
  input  logic [MemW-1:0]  startMem,
  input  logic [LenW-1:0]  startLen,
  output logic             isErase,
  output logic [AddrW-1:0] curOffset,
  output logic [MemW-1:0]  curMem,
  output logic [LenW-1:0]  chunkLen,
  output logic             lastChunk,
  output logic             chunkOk,
  output logic             loopOver,
  output logic             pollOver
);
  localparam int PageBits = $clog2(PageBytes);
  localparam int AttW     = $clog2(MaxAttempts + 1);
  localparam int CompW    = $clog2(NeedDone + 1);
  localparam int PollW    = $clog2(PollLimit + 1);

  logic [LenW-1:0]  remaining;
  logic [AttW-1:0]  attemptCount;
  logic [CompW-1:0] compCount;
  logic [PollW-1:0] pollCount;
  logic [LenW-1:0]  pageRoom;
  logic [LenW-1:0]  stepCap;
  logic [AddrW-1:0] offsetStep;

  // chunk sizing: a program chunk stops at the page edge, an erase step is one sector
  always_comb begin
    pageRoom   = LenW'(PageBytes) - LenW'(curOffset[PageBits-1:0]);
    stepCap    = isErase ? LenW'(SectorBytes) : pageRoom;
    chunkLen   = (remaining < stepCap) ? remaining : stepCap;
    offsetStep = isErase ? AddrW'(SectorBytes) : AddrW'(chunkLen);
  end

  assign lastChunk = (remaining <= chunkLen);
  assign chunkOk   = (compCount == CompW'(NeedDone));
  assign loopOver  = chunkOk || (attemptCount == AttW'(MaxAttempts));
  assign pollOver  = (pollCount == PollW'(PollLimit - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isErase      <= 1'b0;
      curOffset    <= '0;
      curMem       <= '0;
      remaining    <= '0;
      attemptCount <= '0;
      compCount    <= '0;
      pollCount    <= '0;
    end else begin
      if (ctl.load) begin
        isErase      <= startErase;
        curOffset    <= startOffset;
        curMem       <= startMem;
        remaining    <= startLen;
        attemptCount <= '0;
        compCount    <= '0;
      end else if (ctl.advance) begin
        curOffset    <= curOffset + offsetStep;
        curMem       <= curMem + MemW'(chunkLen);
        remaining    <= remaining - chunkLen;
        attemptCount <= '0;
        compCount    <= '0;
      end else if (ctl.attemptEnd) begin
        attemptCount <= attemptCount + 1'b1;
        if (ctl.markDone) compCount <= compCount + 1'b1;
      end
      if (ctl.clrPoll)      pollCount <= '0;
      else if (ctl.incPoll) pollCount <= pollCount + 1'b1;
    end
  end

  AST_ATTEMPT_CAP: assert property (@(posedge clk) disable iff (!rstN)
    attemptCount <= AttW'(MaxAttempts)); // R5
  AST_COMP_CAP: assert property (@(posedge clk) disable iff (!rstN)
    compCount <= CompW'(NeedDone)); // R5
  AST_POLL_CAP: assert property (@(posedge clk) disable iff (!rstN)
    pollCount <= PollW'(PollLimit)); // R6
  AST_ADVANCE_NOT_LAST: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |-> !lastChunk); // R10
endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
#(
  parameter int AddrW     = 24,
  parameter int MemW      = 32,
  parameter int LenW      = 24,
  parameter int PageBytes = 256
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic [LenW-1:0]  startLen,
  input  logic             isErase,
  input  logic [AddrW-1:0] curOffset,
  input  logic [MemW-1:0]  curMem,
  input  logic [LenW-1:0]  chunkLen,
  input  logic             lastChunk,
  input  logic             chunkOk,
  input  logic             loopOver,
  input  logic             pollOver,
  input  logic             cmdAck,
  input  logic             statusBusy,
  output dpCtl_t           ctl,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             cmdValid,
  output logic [7:0]       cmdOpcode,
  output logic             cmdAddrValid,
  output logic [AddrW-1:0] cmdAddr,
  output logic [LenW-1:0]  cmdByteCount,
  output logic [MemW-1:0]  cmdMemAddr
);
  localparam int PageBits = $clog2(PageBytes);

  seqState_e state, nextState;
  logic doneSet, errSet;
  logic accept;

  assign accept = cmdValid && cmdAck;

  always_comb begin
    nextState = state;
    ctl       = '0;
    doneSet   = 1'b0;
    errSet    = 1'b0;
    unique case (state)
      ST_IDLE: if (startPulse) begin
        if (startLen == '0) errSet = 1'b1;
        else begin
          ctl.load  = 1'b1;
          nextState = ST_WREN;
        end
      end
      ST_WREN:   if (accept) nextState = isErase ? ST_PRESR : ST_PROG;
      ST_PRESR:  if (accept) nextState = ST_ERASE;
      ST_ERASE:  if (accept) nextState = ST_POSTSR;
      ST_POSTSR: if (accept) begin
        ctl.clrPoll = 1'b1;
        nextState   = ST_POLL;
      end
      ST_PROG: if (accept) begin
        ctl.clrPoll = 1'b1;
        nextState   = ST_POLL;
      end
      ST_POLL: if (accept) begin
        ctl.incPoll = 1'b1;
        if (!statusBusy) begin
          ctl.attemptEnd = 1'b1;
          ctl.markDone   = 1'b1;
          nextState      = ST_SETTLE;
        end else if (pollOver) begin
          ctl.attemptEnd = 1'b1;
          nextState      = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (loopOver) nextState = isErase ? ST_CHECK : ST_WRDI;
        else          nextState = ST_WREN;
      end
      ST_WRDI: if (accept) nextState = ST_CHECK;
      ST_CHECK: begin
        if (!chunkOk) begin
          errSet    = 1'b1;
          nextState = ST_IDLE;
        end else if (lastChunk) begin
          doneSet   = 1'b1;
          nextState = ST_IDLE;
        end else begin
          ctl.advance = 1'b1;
          nextState   = ST_WREN;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_IDLE;
      done  <= 1'b0;
      error <= 1'b0;
    end else begin
      state <= nextState;
      done  <= doneSet;
      error <= errSet;
    end
  end

  assign busy = (state != ST_IDLE);

  // request fields decoded from the state; datapath registers stay put while a request waits
  always_comb begin
    cmdValid     = 1'b1;
    cmdOpcode    = OP_STAT;
    cmdAddrValid = 1'b0;
    unique case (state)
      ST_WREN:  cmdOpcode = OP_WREN;
      ST_WRDI:  cmdOpcode = OP_WRDI;
      ST_PROG:  begin cmdOpcode = OP_PROG;  cmdAddrValid = 1'b1; end
      ST_ERASE: begin cmdOpcode = OP_ERASE; cmdAddrValid = 1'b1; end
      ST_PRESR, ST_POSTSR, ST_POLL: cmdOpcode = OP_STAT;
      default:  cmdValid = 1'b0;
    endcase
    cmdAddr      = cmdAddrValid ? curOffset : '0;
    cmdMemAddr   = (state == ST_PROG) ? curMem : '0;
    if (state == ST_PROG) cmdByteCount = chunkLen;
    else if (cmdValid && cmdOpcode == OP_STAT) cmdByteCount = LenW'(1);
    else cmdByteCount = '0;
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdAck) |=> (cmdValid && $stable(cmdOpcode) && $stable(cmdAddr)
                               && $stable(cmdByteCount) && $stable(cmdMemAddr))); // R9
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> (done || error)); // R2
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(done && error)); // R2
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R10
  AST_PAGE_FIT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode == OP_PROG) |->
      (cmdByteCount != '0 &&
       (LenW+1)'(cmdAddr[PageBits-1:0]) + (LenW+1)'(cmdByteCount) <= (LenW+1)'(PageBytes))); // R3
  AST_NO_WRDI_ERASE: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && isErase) |-> (cmdOpcode != OP_WRDI)); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !cmdValid); // R1
endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AddrW       = 24,
  parameter int MemW        = 32,
  parameter int LenW        = 24,
  parameter int PageBytes   = 256,
  parameter int SectorBytes = 4096,
  parameter int MaxAttempts = 4,
  parameter int NeedDone    = 2,
  parameter int PollLimit   = 50000,
  parameter int BusyBit     = 0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startPulse,
  input  logic             eraseMode,
  input  logic [AddrW-1:0] startOffset,
  input  logic [MemW-1:0]  startMem,
  input  logic [LenW-1:0]  startLen,
  output logic             busy,
  output logic             done,
  output logic             error,
  output logic             cmdValid,
  output logic [7:0]       cmdOpcode,
  output logic             cmdAddrValid,
  output logic [AddrW-1:0] cmdAddr,
  output logic [LenW-1:0]  cmdByteCount,
  output logic [MemW-1:0]  cmdMemAddr,
  input  logic             cmdAck,
  input  logic [7:0]       cmdStatus
);
  dpCtl_t           ctl;
  logic             isErase;
  logic [AddrW-1:0] curOffset;
  logic [MemW-1:0]  curMem;
  logic [LenW-1:0]  chunkLen;
  logic             lastChunk, chunkOk, loopOver, pollOver;

  fps_datapath #(
    .AddrW(AddrW), .MemW(MemW), .LenW(LenW), .PageBytes(PageBytes),
    .SectorBytes(SectorBytes), .MaxAttempts(MaxAttempts),
    .NeedDone(NeedDone), .PollLimit(PollLimit)
  ) dp_i (
    .clk(clk), .rstN(rstN), .ctl(ctl),
    .startErase(eraseMode), .startOffset(startOffset),
    .startMem(startMem), .startLen(startLen),
    .isErase(isErase), .curOffset(curOffset), .curMem(curMem),
    .chunkLen(chunkLen), .lastChunk(lastChunk), .chunkOk(chunkOk),
    .loopOver(loopOver), .pollOver(pollOver)
  );

  fps_ctrl #(
    .AddrW(AddrW), .MemW(MemW), .LenW(LenW), .PageBytes(PageBytes)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .startLen(startLen),
    .isErase(isErase), .curOffset(curOffset), .curMem(curMem),
    .chunkLen(chunkLen), .lastChunk(lastChunk), .chunkOk(chunkOk),
    .loopOver(loopOver), .pollOver(pollOver),
    .cmdAck(cmdAck), .statusBusy(cmdStatus[BusyBit]),
    .ctl(ctl), .busy(busy), .done(done), .error(error),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdAddrValid(cmdAddrValid),
    .cmdAddr(cmdAddr), .cmdByteCount(cmdByteCount), .cmdMemAddr(cmdMemAddr)
  );
endmodule

// File: tb/flash_prog_seq_tb_top.sv
`timescale 1ns/1ps
module flash_prog_seq_tb_top;
  localparam int AddrW   = 24;
  localparam int MemW    = 32;
  localparam int LenW    = 24;
  localparam int PollLim = 40;
  localparam int LogMax  = 2048;
  localparam int WatchdogCycles = 150000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic eraseMode = 1'b0;
  logic [AddrW-1:0] startOffset = '0;
  logic [MemW-1:0]  startMem = '0;
  logic [LenW-1:0]  startLen = '0;
  logic busy, done, error, cmdValid, cmdAddrValid;
  logic [7:0] cmdOpcode;
  logic [AddrW-1:0] cmdAddr;
  logic [LenW-1:0] cmdByteCount;
  logic [MemW-1:0] cmdMemAddr;
  logic cmdAck = 1'b0;
  logic [7:0] cmdStatus = '0;

  int checks = 0;
  int errors = 0;
  int cycle = 0;

  logic [88:0] expLog [LogMax];
  logic [88:0] actLog [LogMax];
  int expN = 0;
  int actN = 0;
  bit expDone = 1'b0;
  int busyN = 0;
  int phaseIdx = 0;
  int waitLeft = 0;

  always #2.5 clk = ~clk;

  flash_prog_seq #(.PollLimit(PollLim)) dut_i (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .eraseMode(eraseMode),
    .startOffset(startOffset), .startMem(startMem), .startLen(startLen),
    .busy(busy), .done(done), .error(error),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdAddrValid(cmdAddrValid),
    .cmdAddr(cmdAddr), .cmdByteCount(cmdByteCount), .cmdMemAddr(cmdMemAddr),
    .cmdAck(cmdAck), .cmdStatus(cmdStatus)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic void push(logic [7:0] op, logic av, logic [23:0] a,
                               logic [23:0] c, logic [31:0] m);
    if (expN < LogMax) expLog[expN] = {op, av, a, c, m};
    expN++;
  endfunction

  // expected command list from the requirements; the flash model answers busy
  // for the first bn status reads after any other command, then idle
  function automatic void buildExpected(bit er, logic [23:0] off, logic [31:0] mem,
                                        int len, int bn);
    int rem = len;
    logic [23:0] o = off;
    logic [31:0] m = mem;
    expN = 0;
    expDone = 1'b1;
    while (rem > 0) begin
      int room = er ? 4096 : 256 - int'(o[7:0]);
      int ch = (rem < room) ? rem : room;
      int comp = 0;
      int att = 0;
      while (att < 4 && comp < 2) begin
        int idx;
        int polls = 0;
        bit ok = 1'b0;
        push(8'h06, 1'b0, 24'h0, 24'h0, 32'h0);
        if (er) begin
          push(8'h05, 1'b0, 24'h0, 24'h1, 32'h0);
          push(8'h20, 1'b1, o, 24'h0, 32'h0);
          push(8'h05, 1'b0, 24'h0, 24'h1, 32'h0);
          idx = 1;
        end else begin
          push(8'h02, 1'b1, o, 24'(ch), m);
          idx = 0;
        end
        forever begin
          polls++;
          idx++;
          push(8'h05, 1'b0, 24'h0, 24'h1, 32'h0);
          if (idx > bn) begin ok = 1'b1; break; end
          if (polls == PollLim) break;
        end
        if (ok) comp++;
        att++;
      end
      if (!er) push(8'h04, 1'b0, 24'h0, 24'h0, 32'h0);
      if (comp < 2) begin expDone = 1'b0; break; end
      rem -= ch;
      o += er ? 24'd4096 : 24'(ch);
      m += 32'(ch);
    end
  endfunction

  // flash responder: acknowledges after 0..2 extra cycles and logs the request
  initial begin
    forever begin
      @(negedge clk);
      if (cmdAck) cmdAck = 1'b0;
      else if (cmdValid) begin
        if (waitLeft != 0) waitLeft--;
        else begin
          if (actN < LogMax)
            actLog[actN] = {cmdOpcode, cmdAddrValid, cmdAddr, cmdByteCount, cmdMemAddr};
          actN++;
          if (cmdOpcode == 8'h05) begin
            phaseIdx++;
            cmdStatus = {7'($urandom), (phaseIdx > busyN) ? 1'b0 : 1'b1};
          end else begin
            phaseIdx = 0;
            cmdStatus = 8'($urandom);
          end
          cmdAck = 1'b1;
          waitLeft = $urandom_range(2, 0);
        end
      end
    end
  end

  initial begin
    forever begin
      @(posedge clk);
      cycle++;
      if (cycle > WatchdogCycles) begin
        errors++;
        $display("FAIL watchdog expired at cycle %0d", cycle);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
      end
    end
  end

  task automatic runOp(input bit er, input logic [23:0] off, input logic [31:0] mem,
                       input int len, input int bn, input bit inject, input string req);
    int waited = 0;
    bit gotDone = 1'b0;
    bit gotErr = 1'b0;
    int bad = 0;
    busyN = bn;
    buildExpected(er, off, mem, len, bn);
    @(negedge clk);
    actN = 0;
    eraseMode = er;
    startOffset = off;
    startMem = mem;
    startLen = LenW'(len);
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(busy == 1'b1, "R2", "busy after start", longint'(busy), 1);
    while (waited < 40000) begin
      @(negedge clk);
      waited++;
      startPulse = 1'b0;
      if (inject && waited == 7) begin
        startPulse = 1'b1;          // R2: must be ignored while busy
        eraseMode = ~er;
        startOffset = off + 24'h100;
        startMem = 32'hDEAD0000;
        startLen = LenW'(3);
      end
      if (done || error) begin
        gotDone = done;
        gotErr = error;
        break;
      end
    end
    startPulse = 1'b0;
    check(gotDone == expDone && gotErr == !expDone, req, "outcome done/error",
          {gotDone, gotErr}, {expDone, !expDone});
    check(busy == 1'b0, "R2", "busy low at end pulse", longint'(busy), 0);
    check(actN == expN, req, "command count", actN, expN);
    for (int i = 0; i < expN && i < actN && i < LogMax; i++) begin
      if (actLog[i] !== expLog[i]) begin
        if (bad == 0)
          $display("FAIL %s command %0d actual %h expected %h", req, i, actLog[i], expLog[i]);
        bad++;
      end
    end
    checks++;
    if (bad != 0) errors++;
    @(negedge clk);
    check(done == 1'b0 && error == 1'b0, "R10", "pulse lasts one cycle",
          {done, error}, 0);
  endtask

  initial begin
    void'($urandom(32'd20250215));
    repeat (3) @(negedge clk);
    check(busy == 1'b0, "R2", "reset busy", longint'(busy), 0);
    check(done == 1'b0 && error == 1'b0, "R10", "reset pulses", {done, error}, 0);
    check(cmdValid == 1'b0, "R9", "reset request", longint'(cmdValid), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // R1: zero length rejected
    actN = 0;
    startLen = '0;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    check(error == 1'b1, "R1", "zero length error", longint'(error), 1);
    check(busy == 1'b0, "R1", "zero length busy", longint'(busy), 0);
    repeat (4) @(negedge clk);
    check(actN == 0 && error == 1'b0, "R1", "zero length no command", actN, 0);

    runOp(1'b0, 24'h000100, 32'h2000_0000, 256, 0, 1'b0, "R4 R5 R7 R10");
    runOp(1'b0, 24'h0001F0, 32'h0000_0100, 40, 2, 1'b1, "R2 R3 R9");
    runOp(1'b0, 24'h00000A, 32'h0000_4000, 600, 1, 1'b0, "R3 R5");
    runOp(1'b0, 24'h000010, 32'h0000_0040, 5, 0, 1'b0, "R3");
    runOp(1'b0, 24'h000000, 32'h0000_0000, 20, PollLim - 1, 1'b0, "R6 R5");
    runOp(1'b0, 24'h000300, 32'h0000_8000, 300, PollLim, 1'b0, "R6 R7");
    runOp(1'b1, 24'h001234, 32'h0, 9000, 1, 1'b0, "R8");
    runOp(1'b1, 24'h010000, 32'h0, 4096, 100000, 1'b0, "R8 R6");
    for (int t = 0; t < 8; t++) begin
      bit er = ($urandom_range(3, 0) == 0);
      int len = er ? $urandom_range(12000, 1) : $urandom_range(700, 1);
      runOp(er, 24'($urandom_range(24'hEFFFFF, 0)), $urandom, len,
            $urandom_range(3, 0), bit'($urandom_range(1, 0)), "R3 R5 R8 R9");
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule